// File: doc/BRIEF.md
# Sequential Shift-and-Add Integer Multiplier

This block multiplies two 32-bit integers over many clock cycles and returns the full 64-bit product as a high word and a low word. It is built from one 32-bit adder and one double-width accumulator register. The multiplier operand is placed in the low half of that register. Each step looks at the register's least significant bit and, if it is set, adds the multiplicand into the upper half. The whole register, together with the adder's carry, then moves right by one place. The multiplicand register itself never shifts.

A one-cycle start strobe, sampled while the block is idle, captures both operands and a mode select (signed or unsigned). `busy_o` stays high while the operation runs. `done_o` pulses for one cycle in the cycle where the result appears. In signed mode, both operands are reduced to their magnitudes and multiplied as unsigned numbers. If the operand signs differ, the product is negated in one extra cycle. The block never flags overflow: the full 64-bit product is always delivered.

Top module: `smul_top`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and both result words are 0.
- R2: A `start_i` pulse seen while `busy_o` is 0 starts an operation, and `busy_o` is 1 in the next cycle.
- R3: With `signed_i`=0, {`prod_hi_o`,`prod_lo_o`} equals the unsigned 64-bit product of `opa_i` and `opb_i`.
- R4: With `signed_i`=1, {`prod_hi_o`,`prod_lo_o`} equals the two's-complement 64-bit product of the operands. This includes operands of -2^31.
- R5: When no negation is needed, `done_o` is 1 in the 32nd cycle after the cycle in which the start was sampled. `busy_o` is 0 in that same cycle.
- R6: With `signed_i`=1 and operand sign bits (bit 31) that differ, `done_o` comes one cycle later, in the 33rd cycle. With equal sign bits it comes in the 32nd cycle.
- R7: `done_o` stays high for exactly one cycle per operation.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation's result and latency do not change, and no second operation follows.
- R9: Both result words keep their value while the block is idle. They change only when an operation completes.
- R10: The adder carry is shifted into bit 63, so that products with the top bit set come out exact, for example 0xFFFFFFFF × 0xFFFFFFFF = 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opa_i | input | 32 | Multiplicand |
| opb_i | input | 32 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| prod_hi_o | output | 32 | Upper 32 bits of the product |
| prod_lo_o | output | 32 | Lower 32 bits of the product |

## Verification
Random operand pairs in both modes exercise the add-or-skip decision across mixed bit patterns and check the product against a bench-computed reference. Directed cases cover several corners:
- All-ones operands, unsigned, which need the carry into bit 63.
- -2^31 in signed mode, whose magnitude fills all 32 bits.
- Zero operands.
- Each pairing of operand signs, which separates the 32-cycle path from the 33-cycle negation path.

Start pulses injected mid-operation show whether a busy request is really dropped. Idle gaps between operations show whether the result words hold.

// File: rtl/smul_pkg.sv
package smul_pkg;
  parameter int unsigned DEF_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIX  = 2'd2
  } smul_phase_e;
endpackage

// File: rtl/smul_prep.sv
module smul_prep #(
  parameter int unsigned W = smul_pkg::DEF_W
) (
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o
);
  // Magnitude of a value; in unsigned mode the value passes unchanged.
  function automatic logic [W-1:0] magnitude(input logic s, input logic [W-1:0] x);
    return (s && x[W-1]) ? (~x + W'(1)) : x;
  endfunction

  assign mag_a_o = magnitude(sgn_i, a_i);
  assign mag_b_o = magnitude(sgn_i, b_i);
  assign neg_o   = sgn_i && (a_i[W-1] ^ b_i[W-1]);
endmodule

// File: rtl/smul_engine.sv
module smul_engine #(
  parameter int unsigned W = smul_pkg::DEF_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           run_o,
  output logic           last_o,
  output logic [2*W-1:0] acc_o,
  output logic [2*W-1:0] acc_nxt_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(W + 1);

  logic [PW-1:0] acc_q;
  logic [W-1:0]  mc_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  // One iteration: optional add into the upper half, then a right shift
  // that moves the adder carry into the top bit.
  function automatic logic [PW-1:0] add_shift(input logic [PW-1:0] acc, input logic [W-1:0] mc);
    logic [W:0] s;
    s = {1'b0, acc[PW-1:W]} + (acc[0] ? {1'b0, mc} : {(W+1){1'b0}});
    return {s, acc[W-1:1]};
  endfunction

  assign acc_nxt_o = add_shift(acc_q, mc_q);
  assign last_o    = run_q && (cnt_q == CW'(W - 1));
  assign run_o     = run_q;
  assign acc_o     = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i && !run_q) begin
      acc_q <= {{W{1'b0}}, mplier_i};
      mc_q  <= mcand_i;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      acc_q <= acc_nxt_o;
      cnt_q <= cnt_q + CW'(1);
      if (last_o) run_q <= 1'b0;
    end
  end

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (acc_q[PW-1:W] == '0));
  // R3
  skip_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !acc_q[0]) |=> (acc_q == ($past(acc_q) >> 1)));
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < CW'(W)));
endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int unsigned W = smul_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_req;
  logic          run, last;
  logic [PW-1:0] acc, acc_nxt;
  logic          fix_q, neg_q, done_q;
  logic [PW-1:0] res_q;
  logic          start_ok;

  function automatic logic [PW-1:0] negate(input logic [PW-1:0] x);
    return ~x + PW'(1);
  endfunction

  smul_prep #(.W(W)) u_prep (
    .sgn_i(signed_i), .a_i(opa_i), .b_i(opb_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg_req)
  );

  smul_engine #(.W(W)) u_engine (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok),
    .mcand_i(mag_a), .mplier_i(mag_b),
    .run_o(run), .last_o(last), .acc_o(acc), .acc_nxt_o(acc_nxt)
  );

  assign busy_o    = run || fix_q;
  assign start_ok  = start_i && !busy_o;
  assign done_o    = done_q;
  assign prod_hi_o = res_q[PW-1:W];
  assign prod_lo_o = res_q[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) neg_q <= neg_req;
      if (last) begin
        if (neg_q) begin
          fix_q <= 1'b1;
        end else begin
          res_q  <= acc_nxt;
          done_q <= 1'b1;
        end
      end
      if (fix_q) begin
        res_q  <= negate(acc);
        fix_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R5
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R6
  fix_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_q |-> (neg_q && !run));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable({prod_hi_o, prod_lo_o}));
endmodule

// File: tb/smul_top_tb.sv
module smul_top_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] prod_hi_o, prod_lo_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smul_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
  );

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic signed [63:0] sa, sb;
    if (s) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return 64'(sa * sb);
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally pokes start mid-run with other operands.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input bit poke, input string req);
    int cyc;
    int exp_lat;
    logic [63:0] prev;
    exp_lat = (s && (a[31] ^ b[31])) ? 33 : 32;
    @(negedge clk);
    opa_i = a; opb_i = b; signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    check("R2 busy after start", {63'd0, busy_o}, 64'd1);
    while (!done_o && cyc < 100) begin
      if (poke && cyc == 10) begin
        opa_i = 32'h1234_5678; opb_i = 32'h0000_0003; signed_i = ~s; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check({req, " product"}, {prod_hi_o, prod_lo_o}, ref_prod(a, b, s));
    check(s ? "R6 latency" : "R5 latency", 64'(cyc), 64'(exp_lat));
    check("R5 busy low at done", {63'd0, busy_o}, 64'd0);
    prev = {prod_hi_o, prod_lo_o};
    @(negedge clk);
    check("R7 done single pulse", {63'd0, done_o}, 64'd0);
    if (poke) check("R8 no second operation", {63'd0, busy_o}, 64'd0);
    repeat (2) @(negedge clk);
    check("R9 result held while idle", {prod_hi_o, prod_lo_o}, prev);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 busy reset", {63'd0, busy_o}, 64'd0);
    check("R1 done reset", {63'd0, done_o}, 64'd0);
    check("R1 result reset", {prod_hi_o, prod_lo_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd3, 32'd5, 1'b0, 1'b0, "R3 small");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R10 all ones");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, "R10 top bits");
    run_op(32'd0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R3 zero");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, "R4 neg times pos");
    run_op(32'hFFFF_FFFE, 32'hFFFF_FFFD, 1'b1, 1'b0, "R4 neg times neg");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R4 min times min");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, "R4 min times max");
    run_op(32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4 zero times neg");
    run_op(32'hABCD_0123, 32'h7654_3210, 1'b0, 1'b1, "R8 poke unsigned");
    run_op(32'hF000_0001, 32'h0000_0101, 1'b1, 1'b1, "R8 poke signed");

    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom;
      b = $urandom;
      s = 1'($urandom);
      run_op(a, b, s, 1'b0, s ? "R4 random" : "R3 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule